// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block recovers stereo PCM samples from a three-wire serial audio link: a bit clock, a frame clock that separates the two channels, and a data line. All three wires come from an external source and are resampled by a faster system clock. The bit clock's rising edges are detected in the system domain, and each detected edge shifts in one data bit.

Two format-select pins pick one of four word placements inside each channel slot: right-justified 16-bit, right-justified 18-bit, left-justified 18-bit, and an I2S-style layout in which the word starts one bit clock after the frame clock changes. Whatever the format, the block delivers both channels as 18-bit two's-complement values, aligned to the most significant bit, and raises a one-cycle strobe once per frame when the right-channel word is complete. Downstream filtering takes the pair when the strobe fires.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is low and after it is released, `left_out` and `right_out` read zero and `frame_valid` is low until a full frame has been received.
- R2: `fmt_sel` selects the layout: 2'b00 right-justified 16-bit, 2'b01 right-justified 18-bit, 2'b10 left-justified 18-bit, 2'b11 I2S-style. The format is held steady from reset onward.
- R3: Data is MSB first, two's complement, and is taken at the value present when `bick_in` rises. `bick_in` stays high and low for at least three system clock periods each, and all three serial inputs pass through the same two-stage synchronizer.
- R4: In format 2'b00 the 16 bits just before a frame-clock change form the word. It is output shifted left by two with bits [1:0] zero, and earlier bits of the slot have no effect.
- R5: In format 2'b01 the 18 bits just before a frame-clock change form the word, and earlier bits of the slot have no effect.
- R6: In format 2'b10 the first 18 bits from the frame-clock change form the word, and later bits of the slot have no effect.
- R7: In format 2'b11 capture starts one bit clock after the frame-clock change, and `lrck_in` low marks the left channel. With 16 bit clocks per channel the 16-bit word is placed in bits [17:2] and bits [1:0] are zero. With 18 or more, the first 18 bits form the word.
- R8: In formats 2'b00, 2'b01 and 2'b10, `lrck_in` high marks the left channel.
- R9: `frame_valid` is a single-cycle pulse, issued once per frame after the right word completes and only when the left word of the same frame was also complete. At least 30 bit-clock rises separate two pulses, or a pulse from reset.
- R10: `left_out` and `right_out` change only in the cycle that `frame_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_sel | input | 2 | Serial layout select |
| bick_in | input | 1 | External serial bit clock |
| lrck_in | input | 1 | External frame clock (channel select) |
| sdata_in | input | 1 | Serial data, MSB first |
| left_out | output | 18 | Left sample, two's complement, MSB aligned |
| right_out | output | 18 | Right sample, two's complement, MSB aligned |
| frame_valid | output | 1 | One-cycle strobe when a stereo pair is ready |

## Verification
The bench goes after slot-boundary placement: it sends the minimum slot width and a wider, padded slot in every format. It fills the padding with ones, so a receiver that counted from the wrong end of the slot returns corrupted words. Full-scale positive (1FFFFh), full-scale negative (20000h), zero and mixed patterns use distinct left and right values, so a swapped channel polarity or an I2S receiver that did not skip the first bit clock shows up as a mismatch. The exactly-32-bit-clocks I2S frame, whose LSB arrives after the frame clock has already changed, checks the one-bit delay and the 16-to-18-bit widening together. An extra strobe or a lost first frame after reset shows up as an unmatched scoreboard entry.

// File: rtl/asr_pkg.sv
// Shared types for the audio serial receiver.
package asr_pkg;
    // Serial layout codes as driven on the format-select pins (R2).
    typedef enum logic [1:0] {
        FMT_RJ16 = 2'b00,
        FMT_RJ18 = 2'b01,
        FMT_LJ18 = 2'b10,
        FMT_I2S  = 2'b11
    } asr_fmt_e;
endpackage

// File: rtl/asr_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes every bit of the bundle is sampled with the same latency so
// relative timing between the wires is preserved (R3).
module asr_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/asr_framer.sv
// Detects bit-clock rises and channel-slot boundaries.
// In the I2S-style layout the frame clock is delayed by one bit clock
// so that the word always starts at the first bit of a delayed slot.
// Assumes the format is constant from reset onward.
module asr_framer
    import asr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  asr_fmt_e fmt,
    input  logic     bick_s,
    input  logic     lrck_s,
    output logic     bit_stb,   // one cycle per bit-clock rise
    output logic     boundary,  // this bit opens a new slot
    output logic     half_end,  // a complete slot just ended
    output logic     end_left   // the slot that ended was left
);
    logic bick_q, lr1, lr2, seen;
    logic i2s, frm_now, frm_prev;

    assign i2s      = (fmt == FMT_I2S);
    assign bit_stb  = bick_s & ~bick_q;
    assign frm_now  = i2s ? lr1 : lrck_s;   // R7: one bit clock of delay
    assign frm_prev = i2s ? lr2 : lr1;
    assign boundary = bit_stb & (frm_now != frm_prev);
    assign half_end = boundary & seen;
    assign end_left = (frm_prev == ~i2s);   // R7 / R8 channel polarity

    // Track bit-clock level, frame-clock history and first-boundary flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bick_q <= 1'b0;
            lr1    <= i2s;      // start in the "right" level for the format
            lr2    <= i2s;
            seen   <= 1'b0;
        end else begin
            bick_q <= bick_s;
            if (bit_stb) begin
                lr1 <= lrck_s;
                lr2 <= lr1;
                if (frm_now != frm_prev) seen <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/asr_deser.sv
// Shifts serial bits into two registers: a tail window holding the most
// recent bits (right-justified layouts) and a head window holding the
// first bits of the slot (left-justified and I2S-style layouts).
// Presents the finished word of the slot that is closing.
module asr_deser
    import asr_pkg::*;
#(
    parameter int SAMPLE_W = 18,
    parameter int SHORT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  asr_fmt_e            fmt,
    input  logic                bit_stb,
    input  logic                bit_val,
    input  logic                boundary,
    output logic [SAMPLE_W-1:0] word
);
    localparam int CW = $clog2(SAMPLE_W + 1);
    localparam logic [CW-1:0] FULL = CW'(SAMPLE_W);
    localparam int PADW = SAMPLE_W - SHORT_W;

    logic [SAMPLE_W-1:0] tail, head;
    logic [CW-1:0]       hcnt;

    // Update both windows on each bit; the head window restarts per slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail <= '0;
            head <= '0;
            hcnt <= '0;
        end else if (bit_stb) begin
            tail <= {tail[SAMPLE_W-2:0], bit_val};
            if (boundary) begin
                head <= {{(SAMPLE_W-1){1'b0}}, bit_val};
                hcnt <= CW'(1);
            end else if (hcnt < FULL) begin
                head <= {head[SAMPLE_W-2:0], bit_val};
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    // Select and MSB-align the word for the active layout (R4..R7).
    always_comb begin
        unique case (fmt)
            FMT_RJ16: word = {tail[SHORT_W-1:0], {PADW{1'b0}}};
            FMT_RJ18: word = tail;
            default:  word = head << (FULL - hcnt);
        endcase
    end
endmodule

// File: rtl/audio_serial_rx.sv
// Top of the multi-format audio serial receiver.
// Synchronizes the serial wires, frames them into channel slots,
// deserializes each slot and publishes a stereo pair once per frame.
// Assumes the bit clock phases each last at least three clk periods.
module audio_serial_rx
    import asr_pkg::*;
#(
    parameter int SAMPLE_W    = 18,
    parameter int SHORT_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          fmt_sel,
    input  logic                bick_in,
    input  logic                lrck_in,
    input  logic                sdata_in,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                frame_valid
);
    asr_fmt_e            fmt;
    logic [2:0]          raw, syn;
    logic                bit_stb, boundary, half_end, end_left;
    logic [SAMPLE_W-1:0] word, left_hold;
    logic                left_ok;

    assign fmt = asr_fmt_e'(fmt_sel);
    assign raw = {bick_in, lrck_in, sdata_in};

    asr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw), .dout(syn)
    );

    asr_framer u_framer (
        .clk(clk), .rst_n(rst_n), .fmt(fmt),
        .bick_s(syn[2]), .lrck_s(syn[1]),
        .bit_stb(bit_stb), .boundary(boundary),
        .half_end(half_end), .end_left(end_left)
    );

    asr_deser #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_deser (
        .clk(clk), .rst_n(rst_n), .fmt(fmt),
        .bit_stb(bit_stb), .bit_val(syn[0]), .boundary(boundary),
        .word(word)
    );

    // Pair a completed left word with the following right word (R9, R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold   <= '0;
            left_ok     <= 1'b0;
            left_out    <= '0;
            right_out   <= '0;
            frame_valid <= 1'b0;
        end else begin
            frame_valid <= 1'b0;
            if (half_end) begin
                if (end_left) begin
                    left_hold <= word;
                    left_ok   <= 1'b1;
                end else if (left_ok) begin
                    left_out    <= left_hold;
                    right_out   <= word;
                    frame_valid <= 1'b1;
                    left_ok     <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/audio_serial_rx_chk.sv
// Property checker for the audio serial receiver, attached by bind.
// Counts raw bit-clock rises to bound the strobe rate without deep $past.
module audio_serial_rx_chk #(
    parameter int SAMPLE_W = 18
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          fmt_sel,
    input logic                bick_in,
    input logic [SAMPLE_W-1:0] left_out,
    input logic [SAMPLE_W-1:0] right_out,
    input logic                frame_valid
);
    logic       bick_prev;
    logic [5:0] rise_cnt;

    // Count bit-clock rises seen since reset or the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bick_prev <= 1'b0;
            rise_cnt  <= '0;
        end else begin
            bick_prev <= bick_in;
            if (frame_valid)
                rise_cnt <= '0;
            else if (bick_in && !bick_prev && rise_cnt != 6'd63)
                rise_cnt <= rise_cnt + 1'b1;
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);                                  // R9
    AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> rise_cnt >= 6'd30);                             // R9
    AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> ($stable(left_out) && $stable(right_out)));    // R10
    AST_RJ16_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && fmt_sel == 2'b00) |->
            (left_out[1:0] == 2'b00 && right_out[1:0] == 2'b00));       // R4
endmodule

bind audio_serial_rx audio_serial_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bick_in(bick_in),
    .left_out(left_out), .right_out(right_out), .frame_valid(frame_valid)
);

// File: tb/sim_audio_serial_rx.sv
// Scoreboard bench: the driver queues expected pairs, the monitor pops
// and compares them on every strobe.
module sim_audio_serial_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic        bick_in = 1'b0, lrck_in = 1'b0, sdata_in = 1'b0;
    logic [17:0] left_out, right_out;
    logic        frame_valid;

    int     n_chk = 0, n_fail = 0;
    string  tag = "R4";
    logic   carry = 1'b0;
    logic   hold_bad = 1'b0;
    logic [17:0] seen_l = '0, seen_r = '0;
    logic [35:0] exp_q [$];

    always #4 clk = ~clk;   // 125 MHz

    audio_serial_rx u0 (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
        .bick_in(bick_in), .lrck_in(lrck_in), .sdata_in(sdata_in),
        .left_out(left_out), .right_out(right_out), .frame_valid(frame_valid)
    );

    task automatic chk(input logic ok, input string rq, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Bit placed at slot position s for a word w (before any I2S delay).
    function automatic logic slot_bit(input int f, input int n, input int s,
                                      input logic [17:0] w, input logic pad);
        int wl;
        case (f)
            0: return (s >= n - 16) ? w[17 - (s - (n - 16))] : pad;
            1: return (s >= n - 18) ? w[17 - (s - (n - 18))] : pad;
            2: return (s < 18) ? w[17 - s] : pad;
            default: begin
                wl = (n >= 18) ? 18 : 16;
                return (s < wl) ? w[17 - s] : pad;
            end
        endcase
    endfunction

    function automatic logic [17:0] exp_word(input int f, input int n,
                                             input logic [17:0] w);
        if (f == 0 || (f == 3 && n < 18)) return {w[17:2], 2'b00};
        return w;
    endfunction

    // Drive one channel slot; data and frame clock change while BICK is low.
    task automatic send_half(input int f, input int n, input logic [17:0] w,
                             input logic lvl, input logic pad);
        for (int s = 0; s < n; s++) begin
            logic b;
            b = slot_bit(f, n, s, w, pad);
            @(negedge clk);
            bick_in = 1'b0;
            lrck_in = lvl;
            if (f == 3) begin
                sdata_in = carry;
                carry = b;
            end else begin
                sdata_in = b;
            end
            repeat (3) @(negedge clk);
            bick_in = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic send_frame(input int f, input int n, input logic [17:0] l,
                              input logic [17:0] r, input logic pad,
                              input logic push);
        logic lv;
        lv = (f == 3) ? 1'b0 : 1'b1;   // R7 / R8 channel polarity
        if (push) exp_q.push_back({exp_word(f, n, l), exp_word(f, n, r)});
        send_half(f, n, l, lv, pad);
        send_half(f, n, r, ~lv, pad);
    endtask

    task automatic do_reset(input int f);
        @(negedge clk);
        rst_n = 1'b0;
        fmt_sel = 2'(f);
        bick_in = 1'b0;
        lrck_in = (f == 3) ? 1'b1 : 1'b0;
        sdata_in = 1'b0;
        carry = 1'b0;
        exp_q.delete();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic drain(input string rq);
        send_frame(int'(fmt_sel), 18, 18'h0, 18'h0, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, rq, "pending frames after flush",
            36'(exp_q.size()), 36'd0);
    endtask

    // Monitor: compare each strobe with the scoreboard; watch output holding.
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "strobe with nothing expected",
                        {left_out, right_out}, 36'd0);
                end else begin
                    logic [35:0] e;
                    e = exp_q.pop_front();
                    chk(left_out == e[35:18], tag, "left word",
                        36'(left_out), 36'(e[35:18]));
                    chk(right_out == e[17:0], tag, "right word",
                        36'(right_out), 36'(e[17:0]));
                end
                seen_l <= left_out;
                seen_r <= right_out;
            end else if (left_out != seen_l || right_out != seen_r) begin
                hold_bad <= 1'b1;   // R10
            end
        end else begin
            seen_l <= '0;
            seen_r <= '0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 36'd0, 36'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset(0);
        chk(left_out == 18'h0, "R1", "left after reset", 36'(left_out), 36'd0);
        chk(right_out == 18'h0, "R1", "right after reset", 36'(right_out), 36'd0);
        chk(frame_valid == 1'b0, "R1", "strobe after reset", 36'(frame_valid), 36'd0);

        // R4 (R2 code 00): right-justified 16-bit, 32 and 64 bit clocks per frame
        tag = "R4";
        send_frame(0, 16, 18'h1FFFF, 18'h20000, 1'b0, 1'b1);
        send_frame(0, 16, 18'h2A5C3, 18'h15A3C, 1'b0, 1'b1);
        send_frame(0, 32, 18'h0F0F0, 18'h30303, 1'b1, 1'b1);
        drain("R4");

        // R5 (R2 code 01): right-justified 18-bit, R3 MSB first
        do_reset(1);
        tag = "R5";
        send_frame(1, 18, 18'h1FFFF, 18'h20000, 1'b0, 1'b1);
        send_frame(1, 32, 18'h00001, 18'h2AAAA, 1'b1, 1'b1);
        send_frame(1, 18, 18'h00000, 18'h3FFFF, 1'b0, 1'b1);
        drain("R5");

        // R6 (R2 code 10): left-justified 18-bit, R8 polarity
        do_reset(2);
        tag = "R6";
        send_frame(2, 18, 18'h20000, 18'h1FFFF, 1'b0, 1'b1);
        send_frame(2, 32, 18'h12345, 18'h2BCDE, 1'b1, 1'b1);
        send_frame(2, 32, 18'h3FFFC, 18'h00000, 1'b1, 1'b1);
        drain("R6");

        // R7 (R2 code 11): I2S-style, 32 bit clocks (16-bit) and wider frames
        do_reset(3);
        tag = "R7";
        send_frame(3, 16, 18'h1FFFF, 18'h20000, 1'b0, 1'b1);
        send_frame(3, 16, 18'h2A5C3, 18'h15A3C, 1'b0, 1'b1);
        drain("R7");
        do_reset(3);
        send_frame(3, 18, 18'h00001, 18'h2FFFE, 1'b0, 1'b1);
        send_frame(3, 32, 18'h155AA, 18'h2AA55, 1'b1, 1'b1);
        drain("R7");

        chk(hold_bad == 1'b0, "R10", "outputs moved without strobe",
            36'(hold_bad), 36'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule